// File: doc/BRIEF.md
# GPIO Bank Pin-Event Interrupt Unit

This block watches the 32 already-synchronized pin levels of one GPIO bank and raises a single bank interrupt when a configured pin condition occurs. Every pin is programmed on its own to react to a rising edge, a falling edge, either edge, a high level or a low level. A detected event sets a sticky status bit. Software clears that bit by writing a one to it. A per-pin mask decides which status bits reach the interrupt output. The mask is changed only through two write-only strobe registers: one unmasks pins and one masks them.

Masking blocks only the propagation of an event. Detection and latching continue while a pin is masked. A condition that occurred while the pin was masked therefore appears on the interrupt output as soon as the pin is unmasked. Software that does not want such stale events clears the status bit before it unmasks the pin. The register port is a plain single-cycle bus. Read data is registered and is returned one cycle after the request, together with a valid strobe.

Register map (word addresses on `bus_addr`):

| Address | Access | Meaning |
|---|---|---|
| 0 | read/write | trigger kind: 1 = edge, 0 = level |
| 1 | read/write | sense: 1 = rising or high, 0 = falling or low |
| 2 | read/write | dual edge: 1 = an edge pin reacts to both edges |
| 3 | write-only | unmask strobe |
| 4 | write-only | mask strobe |
| 5 | read-only | mask, 1 = masked |
| 6 | read / write-one-to-clear | status |

Reads of addresses 3, 4 and 7 return zero.

Top module: `pin_event_irq_unit`

## Requirements
- R1: After reset the mask reads all ones, the status reads zero, the configuration registers at addresses 0, 1 and 2 read zero, and `irq` is low.
- R2: A value written to address 0, 1 or 2 reads back unchanged. Read data appears with `bus_rvld` one cycle after `bus_rd`.
- R3: A pin with kind=1, sense=1 and dual=0 sets its status bit on a low-to-high change and not on a high-to-low change. Edges are found by comparing the current level with the level registered one cycle earlier, so the status bit is set on the clock edge that first samples the new level.
- R4: A pin with kind=1, sense=0 and dual=0 sets its status bit on a high-to-low change and not on a low-to-high change.
- R5: A pin with kind=1 and dual=1 sets its status bit on both edges, whatever its sense bit holds.
- R6: A pin with kind=0 sets its status bit on every cycle in which its level equals the sense bit. If that level is still present, the bit sets again on the cycle after it is cleared.
- R7: The dual bit has no effect on a pin with kind=0. With dual=1, a level-low pin does not react to a low-to-high change.
- R8: Writing to address 3 clears the mask bits written as one. Writing to address 4 sets the mask bits written as one. Bits written as zero leave the mask unchanged, and a write of all ones to address 4 masks every pin.
- R9: Writing to address 6 clears the status bits written as one. Bits written as zero leave the status unchanged, and a set status bit stays set until it is cleared.
- R10: Detection and status latching continue while a pin is masked. `irq` stays low while every pin is masked, and a pending bit drives `irq` once its pin is unmasked.
- R11: `irq` is registered. It is high in the cycle after any bit of status AND NOT mask is set, and it falls in the cycle after no such bit remains.
- R12: When a clear and a new event reach the same status bit in the same cycle, the bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 3 | register word address |
| bus_wdata | input | NPINS | write data |
| bus_rdata | output | NPINS | registered read data |
| bus_rvld | output | 1 | read data valid, one cycle after bus_rd |
| pin_lvl | input | NPINS | synchronized pin levels |
| irq | output | 1 | registered bank interrupt |

## Verification
A wrong previous-level register or a wrong mode decode shows as a status bit that is missing or extra on the very next status read. This happens one cycle after the pin change that should or should not have been detected. A wrong mask or status update appears on `irq` one cycle later than on the status or mask read. The bench therefore checks `irq` on the exact cycles just before and just after each unmask and each clear. The case where a clear and an event collide is driven on the same clock edge, so an ordering error between the two leaves the bit clear when it should stay set.

// File: rtl/pei_pkg.sv
package pei_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_KIND    = 3'd0,
    A_SENSE   = 3'd1,
    A_DUAL    = 3'd2,
    A_UNMASK  = 3'd3,
    A_MASKSET = 3'd4,
    A_MASK    = 3'd5,
    A_STATUS  = 3'd6,
    A_NONE    = 3'd7
  } reg_sel_e;

  // One-pin event decision from the current and the previous sampled level.
  function automatic logic pin_event(input logic cur, input logic prev,
                                     input logic kind, input logic sense,
                                     input logic dual);
    logic rise, fall;
    rise = cur & ~prev;
    fall = ~cur & prev;
    if (kind) begin
      if (dual) return rise | fall;
      return sense ? rise : fall;
    end
    return sense ? cur : ~cur;
  endfunction
endpackage

// File: rtl/pei_cfg.sv
module pei_cfg
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  input  logic [NPINS-1:0]  wdata,
  input  logic [NPINS-1:0]  status,
  output logic [NPINS-1:0]  cfg_kind,
  output logic [NPINS-1:0]  cfg_sense,
  output logic [NPINS-1:0]  cfg_dual,
  output logic [NPINS-1:0]  mask,
  output logic [NPINS-1:0]  sts_clr,
  output logic [NPINS-1:0]  rdata,
  output logic              rd_vld
);
  reg_sel_e sel;
  logic [NPINS-1:0] unmask_bits, maskset_bits, mask_nxt, rd_mux;

  assign sel = reg_sel_e'(addr);

  always_comb begin
    unmask_bits  = '0;
    maskset_bits = '0;
    sts_clr      = '0;
    if (wr) begin
      case (sel)
        A_UNMASK:  unmask_bits  = wdata;
        A_MASKSET: maskset_bits = wdata;
        A_STATUS:  sts_clr      = wdata;
        default: ;
      endcase
    end
    // a mask request beats an unmask request on the same bit
    mask_nxt = (mask & ~unmask_bits) | maskset_bits;
  end

  always_comb begin
    case (sel)
      A_KIND:   rd_mux = cfg_kind;
      A_SENSE:  rd_mux = cfg_sense;
      A_DUAL:   rd_mux = cfg_dual;
      A_MASK:   rd_mux = mask;
      A_STATUS: rd_mux = status;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_kind  <= '0;
      cfg_sense <= '0;
      cfg_dual  <= '0;
      mask      <= '1;
      rdata     <= '0;
      rd_vld    <= 1'b0;
    end else begin
      if (wr) begin
        case (sel)
          A_KIND:  cfg_kind  <= wdata;
          A_SENSE: cfg_sense <= wdata;
          A_DUAL:  cfg_dual  <= wdata;
          default: ;
        endcase
      end
      mask   <= mask_nxt;
      rd_vld <= rd;
      if (rd) rdata <= rd_mux;
    end
  end

  assert_reset_masked_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&mask));

  assert_maskset_applies_R8: assert property (@(posedge clk) disable iff (rst)
    (wr && sel == A_MASKSET) |=> ((mask & $past(wdata)) == $past(wdata)));
endmodule

// File: rtl/pei_detect.sv
module pei_detect
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pin,
  input  logic [NPINS-1:0] cfg_kind,
  input  logic [NPINS-1:0] cfg_sense,
  input  logic [NPINS-1:0] cfg_dual,
  input  logic [NPINS-1:0] clr,
  output logic [NPINS-1:0] status
);
  logic [NPINS-1:0] prev;
  logic [NPINS-1:0] evt;

  for (genvar i = 0; i < NPINS; i++) begin : g_pin
    // previous level follows the pin even in reset: no false edge at release
    always_ff @(posedge clk) prev[i] <= pin[i];

    assign evt[i] = pin_event(pin[i], prev[i], cfg_kind[i], cfg_sense[i], cfg_dual[i]);

    always_ff @(posedge clk) begin
      if (rst) status[i] <= 1'b0;
      else     status[i] <= (status[i] & ~clr[i]) | evt[i];
    end
  end

  assert_status_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status) & ~$past(clr) & ~status) == '0));

  assert_event_beats_clear_R12: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(evt & clr) & ~status) == '0));
endmodule

// File: rtl/pei_irq.sv
module pei_irq #(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] status,
  input  logic [NPINS-1:0] mask,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(status & ~mask);
  end

  assert_all_masked_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    $past(&mask) |-> !irq);

  assert_irq_rise_pending_R11: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> $past(|status));
endmodule

// File: rtl/pin_event_irq_unit.sv
module pin_event_irq_unit
  import pei_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  bus_wr,
  input  logic                  bus_rd,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [NPINS-1:0]      bus_wdata,
  output logic [NPINS-1:0]      bus_rdata,
  output logic                  bus_rvld,
  input  logic [NPINS-1:0]      pin_lvl,
  output logic                  irq
);
  logic [NPINS-1:0] cfg_kind, cfg_sense, cfg_dual, mask, sts_clr, status;

  pei_cfg #(.NPINS(NPINS)) u_cfg (
    .clk(clk), .rst(rst), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .wdata(bus_wdata), .status(status), .cfg_kind(cfg_kind),
    .cfg_sense(cfg_sense), .cfg_dual(cfg_dual), .mask(mask),
    .sts_clr(sts_clr), .rdata(bus_rdata), .rd_vld(bus_rvld)
  );

  pei_detect #(.NPINS(NPINS)) u_det (
    .clk(clk), .rst(rst), .pin(pin_lvl), .cfg_kind(cfg_kind),
    .cfg_sense(cfg_sense), .cfg_dual(cfg_dual), .clr(sts_clr),
    .status(status)
  );

  pei_irq #(.NPINS(NPINS)) u_irq (
    .clk(clk), .rst(rst), .status(status), .mask(mask), .irq(irq)
  );
endmodule

// File: tb/sim_pin_event_irq_unit.sv
module sim_pin_event_irq_unit;
  localparam int N = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [N-1:0] bus_wdata = '0;
  logic [N-1:0] bus_rdata;
  logic bus_rvld;
  logic [N-1:0] pins = '1;
  logic irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  typedef struct {
    logic [N-1:0] v;
    string tag;
  } exp_t;
  exp_t expq[$];

  always #5 clk = ~clk;

  pin_event_irq_unit #(.NPINS(N)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvld(bus_rvld), .pin_lvl(pins), .irq(irq)
  );

  // monitor: pops expected read data when the design returns it
  always @(negedge clk) begin
    if (!rst && bus_rvld) begin
      exp_t e;
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL %s unexpected read data actual=%h expected=none", "R2", bus_rdata);
      end else begin
        e = expq.pop_front();
        if (bus_rdata !== e.v) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", e.tag, bus_rdata, e.v);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [N-1:0] v, input string tag);
    exp_t e;
    e.v = v; e.tag = tag;
    expq.push_back(e);
    bus_rd = 1'b1; bus_addr = a;
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr_pins(input logic [2:0] a, input logic [N-1:0] d, input logic [N-1:0] p);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; pins = p;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
    wr_pins(a, d, pins);
  endtask

  task automatic chk_irq(input logic v, input string tag);
    total++;
    if (irq !== v) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", tag, irq, v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd_chk(3'd5, '1, "R1 mask");
    rd_chk(3'd6, '0, "R1 status");
    rd_chk(3'd0, '0, "R1 kind");
    rd_chk(3'd1, '0, "R1 sense");
    rd_chk(3'd2, '0, "R1 dual");
    // R2 readback
    wr(3'd0, 32'hF0F0_1234); rd_chk(3'd0, 32'hF0F0_1234, "R2 kind");
    wr(3'd1, 32'h5A5A_00FF); rd_chk(3'd1, 32'h5A5A_00FF, "R2 sense");
    wr(3'd2, 32'h0123_4567); rd_chk(3'd2, 32'h0123_4567, "R2 dual");
    // config: p0 rise, p1 fall, p2 both, p3 level high, p4 level low (dual set on 3,4)
    pins[3] = 1'b0;
    wr(3'd0, 32'h0000_0007);
    wr(3'd1, 32'h0000_000D);
    wr(3'd2, 32'h0000_001C);
    tick();
    wr(3'd6, '1);
    rd_chk(3'd6, '0, "R9 clear all");
    // R3 rising
    pins[0] = 1'b0; tick(); rd_chk(3'd6, 32'h0, "R3 no event on fall");
    pins[0] = 1'b1; tick(); rd_chk(3'd6, 32'h1, "R3 rise sets");
    wr(3'd6, 32'h1);
    // R4 falling
    pins[1] = 1'b0; tick(); rd_chk(3'd6, 32'h2, "R4 fall sets");
    wr(3'd6, 32'h2);
    pins[1] = 1'b1; tick(); rd_chk(3'd6, 32'h0, "R4 no event on rise");
    // R5 dual edge
    pins[2] = 1'b0; tick(); rd_chk(3'd6, 32'h4, "R5 fall sets");
    wr(3'd6, 32'h4);
    pins[2] = 1'b1; tick(); rd_chk(3'd6, 32'h4, "R5 rise sets");
    wr(3'd6, 32'h4);
    // R6 level high, re-sets after clear
    pins[3] = 1'b1; tick(); rd_chk(3'd6, 32'h8, "R6 level high sets");
    wr(3'd6, 32'h8);
    rd_chk(3'd6, 32'h8, "R6 sets again while level held");
    pins[3] = 1'b0; tick();
    wr(3'd6, 32'h8);
    rd_chk(3'd6, 32'h0, "R6 cleared once level gone");
    // R6/R7 level low with dual set: a rise during the clear must not set it
    pins[4] = 1'b0; tick(); rd_chk(3'd6, 32'h10, "R6 level low sets");
    begin
      logic [N-1:0] p;
      p = pins; p[4] = 1'b1;
      wr_pins(3'd6, 32'h10, p);
    end
    rd_chk(3'd6, 32'h0, "R7 dual ignored for level pin");
    // R10 masked detection
    pins[0] = 1'b0; tick();
    pins[0] = 1'b1; tick(); tick();
    chk_irq(1'b0, "R10 masked stays low");
    rd_chk(3'd6, 32'h1, "R10 latched while masked");
    // R8/R11 unmask
    wr(3'd3, 32'h1);
    chk_irq(1'b0, "R11 irq not yet");
    tick();
    chk_irq(1'b1, "R10 pending shows after unmask");
    rd_chk(3'd5, 32'hFFFF_FFFE, "R8 unmask bit0");
    wr(3'd3, 32'h0);
    rd_chk(3'd5, 32'hFFFF_FFFE, "R8 zero bits no effect");
    wr(3'd3, 32'hF0);
    wr(3'd4, 32'h10);
    rd_chk(3'd5, 32'hFFFF_FF1E, "R8 mask and unmask strobes");
    wr(3'd6, 32'h1);
    chk_irq(1'b1, "R11 irq falls one cycle later");
    tick();
    chk_irq(1'b0, "R11 irq low after clear");
    wr(3'd4, '1);
    rd_chk(3'd5, '1, "R8 all ones masks all");
    // R9 zero bits
    pins[1] = 1'b0; tick();
    wr(3'd6, 32'h0);
    rd_chk(3'd6, 32'h2, "R9 zero write keeps status");
    wr(3'd6, 32'h2);
    rd_chk(3'd6, 32'h0, "R9 one write clears");
    // R12 event beats clear
    pins[0] = 1'b0; tick();
    pins[0] = 1'b1; tick();
    pins[0] = 1'b0; tick();
    begin
      logic [N-1:0] p;
      p = pins; p[0] = 1'b1;
      wr_pins(3'd6, 32'h1, p);
    end
    rd_chk(3'd6, 32'h1, "R12 event wins over clear");
    wr(3'd6, 32'h1);
    rd_chk(3'd6, 32'h0, "R12 later clear works");
    tick(); tick();
    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R2 missing read data actual=%0d expected=0", expq.size());
    end
    finish_run();
  end
endmodule